// File: doc/BRIEF.md
# External Interrupt Line Conditioner

This block sits between a small group of external interrupt pins and a hierarchical interrupt controller. Each pin is brought into the clock domain through a synchronizer. It is then qualified by a two-bit sense code, which selects one of four modes: active-high level, active-low level, rising edge or falling edge. The result is gated by a per-line enable and by a global external enable. Edge-sensed lines capture events in a sticky pending bit. Software drops that bit by writing a one to the line's clear bit.

All configuration lives in one 32-bit control word, reached through a single write strobe with data and a read-back bus. Line 0 drives the critical-group request. Lines 1 to 3 drive main-group sources 1 to 3. The global external enable and the critical-routing bit are also presented as outputs for the controller downstream. The block does no priority resolution and no status encoding.

Top module: `xirq_cond`

## Requirements
- R1: While reset is held and right after it, the control word reads 0x00000000 and every request, `master_en_o` and `crit_route_o` are 0.
- R2: A write stores the sense codes (line n at bits [23-2n:22-2n]), the enables (line n at bit 11-n), the global enable (bit 12) and the routing bit (bit 0). These read back as written from the cycle after the write. Every other bit, including the clear bits 27 to 24, reads as 0.
- R3: With sense code 0 (active-high level), a line's request follows its pin two clock edges after the pin changes.
- R4: With sense code 3 (active-low level), a line's request follows the inverted pin with the same two-edge latency.
- R5: With sense code 1 (rising edge), a low-to-high pin transition sets a pending bit three edges after the pin change. The request stays asserted after the pin falls again.
- R6: With sense code 2 (falling edge), only high-to-low pin transitions set the pending bit. A rising transition does not.
- R7: Writing 1 to bit 27-n clears line n's pending bit on that write's edge. Writing 0 there leaves the bit untouched. A new edge arriving on the same cycle as the clear wins.
- R8: For a level-sensed line a clear write has no effect; its request keeps following the pin.
- R9: A request is asserted only when the line's enable bit and the global enable bit 12 are both 1.
- R10: Line 0 drives `crit_req_o`, and lines 1..3 drive `main_req_o[0..2]`. Bit 12 is presented on `master_en_o` and bit 0 on `crit_route_o`.
- R11: Edges on an edge-sensed line are captured while the line is disabled. They show as a request as soon as it is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | NUM_LINES | Raw external interrupt pins, asynchronous |
| reg_wr_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | DW | Control word write data |
| reg_rdata_o | output | DW | Control word read-back |
| crit_req_o | output | 1 | Qualified request of line 0, to the critical group |
| main_req_o | output | NUM_LINES-1 | Qualified requests of lines 1 and up, to the main group |
| master_en_o | output | 1 | Global external enable bit |
| crit_route_o | output | 1 | Critical request routing select bit |

## Verification
The bench builds the block with its default parameters: four lines, a 32-bit control word and a two-stage synchronizer. With these values the full control-bit layout is exercised, so every sense code, enable and clear position is reachable. The directed steps can count fixed latencies of two edges for level lines and three edges for edge lines. A random phase toggles pins every cycle while writing random control words. This reaches clear-versus-new-edge collisions and sense changes while a pending bit is set.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  typedef enum logic [1:0] {
    SENSE_LVL_HI = 2'd0,
    SENSE_RISE   = 2'd1,
    SENSE_FALL   = 2'd2,
    SENSE_LVL_LO = 2'd3
  } sense_e;

  localparam int SENSE_BASE = 16;
  localparam int EN_BASE    = 8;
  localparam int CLR_BASE   = 24;
  localparam int MASTER_BIT = 12;
  localparam int ROUTE_BIT  = 0;

  // bit positions mirror the line index from the top of each field
  function automatic int sense_lsb(input int n, input int lines);
    return SENSE_BASE + 2 * (lines - 1 - n);
  endfunction

  function automatic int en_pos(input int n, input int lines);
    return EN_BASE + (lines - 1 - n);
  endfunction

  function automatic int clr_pos(input int n, input int lines);
    return CLR_BASE + (lines - 1 - n);
  endfunction

  function automatic logic [31:0] keep_mask(input int lines);
    logic [31:0] m;
    m = '0;
    m[MASTER_BIT] = 1'b1;
    m[ROUTE_BIT]  = 1'b1;
    for (int n = 0; n < lines; n++) begin
      m[sense_lsb(n, lines)]     = 1'b1;
      m[sense_lsb(n, lines) + 1] = 1'b1;
      m[en_pos(n, lines)]        = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [31:0] clr_mask(input int lines);
    logic [31:0] m;
    m = '0;
    for (int n = 0; n < lines; n++) m[clr_pos(n, lines)] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DW        = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  output logic [2*NUM_LINES-1:0] sense_o,
  output logic [NUM_LINES-1:0] en_o,
  output logic [NUM_LINES-1:0] clr_o,
  output logic                 master_o,
  output logic                 route_o
);
  localparam logic [31:0] KEEP = keep_mask(NUM_LINES);

  logic [DW-1:0] ctrl_q;
  logic [DW-1:0] ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_i) ctrl_d = wdata_i & KEEP[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_fld
    assign sense_o[2*n +: 2] = ctrl_q[sense_lsb(n, NUM_LINES) +: 2];
    assign en_o[n]           = ctrl_q[en_pos(n, NUM_LINES)];
    assign clr_o[n]          = wr_i & wdata_i[clr_pos(n, NUM_LINES)];
  end

  assign master_o = ctrl_q[MASTER_BIT];
  assign route_o  = ctrl_q[ROUTE_BIT];
  assign rdata_o  = ctrl_q;
endmodule

// File: rtl/xirq_line.sv
module xirq_line
  import xirq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic       master_i,
  output logic       req_o
);
  logic   prev_q;
  logic   pend_q, pend_d;
  logic   edge_mode, hit, lvl, cond;
  sense_e mode;

  always_comb begin
    mode      = sense_e'(sense_i);
    edge_mode = (mode == SENSE_RISE) || (mode == SENSE_FALL);
    hit = 1'b0;
    lvl = 1'b0;
    unique case (mode)
      SENSE_RISE:   hit = sync_i & ~prev_q;
      SENSE_FALL:   hit = ~sync_i & prev_q;
      SENSE_LVL_HI: lvl = sync_i;
      SENSE_LVL_LO: lvl = ~sync_i;
      default:      lvl = 1'b0;
    endcase
    // a fresh edge in the clear cycle survives the clear
    pend_d = edge_mode ? (hit | (pend_q & ~clr_i)) : 1'b0;
    cond   = edge_mode ? pend_q : lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  assign req_o = cond & en_i & master_i;
endmodule

// File: rtl/xirq_cond.sv
module xirq_cond
  import xirq_pkg::*;
#(
  parameter int NUM_LINES   = 4,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] ext_irq_i,
  input  logic                 reg_wr_i,
  input  logic [DW-1:0]        reg_wdata_i,
  output logic [DW-1:0]        reg_rdata_o,
  output logic                 crit_req_o,
  output logic [NUM_LINES-2:0] main_req_o,
  output logic                 master_en_o,
  output logic                 crit_route_o
);
  logic [2*NUM_LINES-1:0] sense;
  logic [NUM_LINES-1:0]   en, clr, synced, req;
  logic                   master;

  xirq_ctrl #(.NUM_LINES(NUM_LINES), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .sense_o(sense), .en_o(en), .clr_o(clr),
    .master_o(master), .route_o(crit_route_o)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    xirq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(ext_irq_i[n]), .q_o(synced[n])
    );
    xirq_line u_line (
      .clk(clk), .rst_n(rst_n), .sync_i(synced[n]),
      .sense_i(sense[2*n +: 2]), .clr_i(clr[n]), .en_i(en[n]),
      .master_i(master), .req_o(req[n])
    );
  end

  assign crit_req_o  = req[0];
  assign main_req_o  = req[NUM_LINES-1:1];
  assign master_en_o = master;
endmodule

// File: rtl/xirq_cond_chk.sv
module xirq_cond_chk
  import xirq_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int DW        = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 reg_wr_i,
  input logic [DW-1:0]        reg_wdata_i,
  input logic [DW-1:0]        reg_rdata_o,
  input logic                 crit_req_o,
  input logic [NUM_LINES-2:0] main_req_o
);
  localparam logic [31:0] KEEP = keep_mask(NUM_LINES);
  localparam logic [31:0] CLRM = clr_mask(NUM_LINES);
  localparam int S0 = sense_lsb(0, NUM_LINES);
  localparam int E0 = en_pos(0, NUM_LINES);

  // R2: clear bits never read back as one
  a_r2_clr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata_o & CLRM[DW-1:0]) == '0);

  // R2: written configuration is visible on the next cycle
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_i |=> reg_rdata_o == ($past(reg_wdata_i) & KEEP[DW-1:0]));

  // R9: global enable gates every request
  a_r9_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[MASTER_BIT] |-> (!crit_req_o && main_req_o == '0));

  // R9: line enable gates line 0
  a_r9_line_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata_o[E0] |-> !crit_req_o);

  // R5: an edge request stays up until a write touches the control word
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_rdata_o[S0 +: 2] == 2'd1 || reg_rdata_o[S0 +: 2] == 2'd2)
      && crit_req_o && !reg_wr_i) |=> crit_req_o);
endmodule

bind xirq_cond xirq_cond_chk #(.NUM_LINES(NUM_LINES), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o), .crit_req_o(crit_req_o), .main_req_o(main_req_o)
);

// File: tb/sim_xirq_cond.sv
module sim_xirq_cond;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  ext;
  logic        reg_wr;
  logic [31:0] wdata, rdata;
  logic        crit, master_en, route;
  logic [2:0]  mainq;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  xirq_cond u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext), .reg_wr_i(reg_wr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .crit_req_o(crit),
    .main_req_o(mainq), .master_en_o(master_en), .crit_route_o(route)
  );

  // requirement-level model: 2 sync stages, prior sample, pending bits
  logic [3:0]  m_s1, m_s2, m_sd, m_pend;
  logic [31:0] m_ctrl;
  localparam logic [31:0] KEEP = 32'h00FF_1F01;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_sd <= '0; m_pend <= '0; m_ctrl <= '0;
    end else begin
      for (int n = 0; n < 4; n++) begin
        logic [1:0] s;
        logic h, ed;
        s  = m_ctrl[22-2*n +: 2];
        ed = (s == 2'd1) || (s == 2'd2);
        h  = (s == 2'd1) ? (m_s2[n] & ~m_sd[n]) :
             (s == 2'd2) ? (~m_s2[n] & m_sd[n]) : 1'b0;
        m_pend[n] <= ed ? (h | (m_pend[n] & ~(reg_wr & wdata[27-n]))) : 1'b0;
      end
      m_s1 <= ext; m_s2 <= m_s1; m_sd <= m_s2;
      if (reg_wr) m_ctrl <= wdata & KEEP;
    end
  end

  function automatic logic [3:0] model_out();
    logic [3:0] o;
    for (int n = 0; n < 4; n++) begin
      logic [1:0] s;
      logic c;
      s = m_ctrl[22-2*n +: 2];
      c = (s == 2'd0) ? m_s2[n] : (s == 2'd3) ? ~m_s2[n] : m_pend[n];
      o[n] = c & m_ctrl[11-n] & m_ctrl[12];
    end
    return o;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; wdata = d; step(); reg_wr = 1'b0; wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] obs();
    return {28'd0, mainq, crit};
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd5417);
    rst_n = 1'b0; ext = '0; reg_wr = 1'b0; wdata = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 req", obs(), 32'h0);
    chk("R1 master/route", {30'd0, master_en, route}, 32'h0);
    rst_n = 1'b1;
    step();
    chk("R1 after release", {rdata[30:0] | obs()[30:0], master_en}, 32'h0);

    wr(32'hFFFF_FFFF);
    chk("R2 readback all ones", rdata, 32'h00FF_1F01);
    wr(32'h0F5A_1A00);
    chk("R2 readback pattern", rdata, 32'h005A_1A00);
    chk("R10 master out", {30'd0, master_en, route}, 32'h2);

    // level high, all enabled
    wr(32'h0F00_1F01);
    ext = 4'b0001; step();
    chk("R3 one edge no change", obs(), 32'h0);
    step();
    chk("R3 level high", obs(), 32'h1);
    ext = 4'b1110; step(); step();
    chk("R10 lines 1-3 to main", obs(), 32'hE);
    chk("R10 route out", {31'd0, route}, 32'h1);

    wr(32'h00FF_1F01);
    chk("R4 level low", obs(), 32'h1);
    ext = 4'b0000; step(); step();
    chk("R4 level low all", obs(), 32'hF);

    // line 1 rising, others level high
    wr(32'h0F10_1F01);
    chk("R5 cleared", obs(), 32'h0);
    ext = 4'b0010; step(); step();
    chk("R5 latency", obs(), 32'h0);
    step();
    chk("R5 rising latched", obs(), 32'h2);
    ext = 4'b0000; step(); step(); step();
    chk("R5 sticky", obs(), 32'h2);
    wr(32'h0010_1F01);
    chk("R7 zero clear keeps", obs(), 32'h2);
    wr(32'h0410_1F01);
    chk("R7 clear", obs(), 32'h0);

    wr(32'h0010_1B01);
    ext = 4'b0010; step(); step(); step(); step();
    chk("R11 disabled", obs(), 32'h0);
    wr(32'h0010_1F01);
    chk("R11 captured while disabled", obs(), 32'h2);

    // line 2 falling, line 1 level high
    wr(32'h0F08_1F01);
    chk("R6 setup", obs(), 32'h2);
    ext = 4'b0110; step(); step(); step(); step();
    chk("R6 rise ignored", obs(), 32'h2);
    ext = 4'b0010; step(); step(); step();
    chk("R6 falling latched", obs(), 32'h6);

    ext = 4'b0011; step(); step();
    chk("R8 setup", obs(), 32'h7);
    wr(32'h0808_1F01);
    chk("R8 clear ignored on level", obs(), 32'h7);
    wr(32'h0008_0F01);
    chk("R9 master off", obs(), 32'h0);
    chk("R9 master out", {31'd0, master_en}, 32'h0);
    wr(32'h0008_1F01);
    chk("R9 master on", obs(), 32'h7);

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      ext = 4'($urandom);
      if ($urandom_range(7, 0) == 0) begin
        logic [31:0] d;
        d = $urandom;
        d[12] = ($urandom_range(3, 0) != 0);
        d[11:8] = d[11:8] | 4'($urandom);
        reg_wr = 1'b1; wdata = d;
      end else begin
        reg_wr = 1'b0; wdata = '0;
      end
      step();
      chk("R5 R6 R7 R11 random req", obs(), {28'd0, model_out()});
      chk("R2 random readback", rdata, m_ctrl);
    end
    reg_wr = 1'b0;

    summary();
    $finish;
  end
endmodule